// File: doc/BRIEF.md
# Framed Peripheral Bus Bridge

This block connects the separate read and write request channels of a 32-bit processor memory bus to one narrower peripheral bus. The peripheral bus has a 16-bit address, a data path that is 16 or 32 bits wide depending on the access, and single-cycle read and write strobes. When both request channels are pending, the write channel is served first. A request is held by the requester until its acknowledge pulse arrives.

Three address windows, called frames, sit on the peripheral side. Each frame has a base and a size set by parameters, a one-hot select line, and its own access policy. The native-wide frame accepts 16-bit and 32-bit accesses. The narrow frame accepts only 16-bit transfers, so the bridge breaks a 32-bit access to it into two half-word transfers and holds the acknowledge until both are done. The DMA frame accepts both widths and is the only window a DMA master may reach.

The bridge turns an access into an error response, with no peripheral strobe, in three cases: the address falls outside every frame, a DMA master targets a non-DMA frame, or a 32-bit access has an odd address. An error response on a read returns zero.

Top module: `pbus_bridge`

## Requirements
- R1: An address in [base, base+size) of frame k drives only bit k of `p_sel_o` (bit 0 native-wide, bit 1 narrow, bit 2 DMA) during the strobe. `p_addr_o` carries the half-word offset address − base. `p_sel_o` is zero whenever no strobe is active.
- R2: For a legal access, the first strobe appears one cycle after the request is accepted. Each strobe lasts one cycle. The acknowledge pulses in the cycle after the last strobe. `p_wr_o` and `p_rd_o` are never high together.
- R3: A 32-bit access to a frame with native wide support is one strobe with `p_wide_o`=1. The full 32-bit write data goes out on `p_wdata_o`, and the full 32 bits of `p_rdata_i` are returned.
- R4: A 32-bit access to the narrow frame is two strobes with `p_wide_o`=0. The first goes to offset o and carries bits 15:0. The second goes to o+1 and carries bits 31:16 on `p_wdata_o[15:0]`. Read data is {second half-word, first half-word}.
- R5: A 16-bit access uses one strobe with `p_wide_o`=0. Write data is {16'h0, data[15:0]}. Read data is {16'h0, `p_rdata_i[15:0]`}.
- R6: A DMA access (`*_dma_i`=1) to the DMA frame is served normally. A DMA access to any other frame gives no strobe and an acknowledge with `err_o`=1 one cycle after acceptance, and a read returns zero.
- R7: An address outside every frame gives no strobe and an acknowledge with `err_o`=1, and a read returns zero.
- R8: A 32-bit access with address bit 0 set gives no strobe and an error acknowledge in every frame.
- R9: When write and read requests are both pending in an idle cycle, the write is served first. The read is served after the write completes.
- R10: While `rst_ni` is low, all strobes, selects, acknowledges and `err_o` are low.
- R11: `err_o` is high only together with an acknowledge. `rd_ack_o` and `wr_ack_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Write request, held until `wr_ack_o` |
| wr_addr_i | input | AW | Write address (half-word units) |
| wr_data_i | input | DW | Write data |
| wr_wide_i | input | 1 | Write is 32-bit |
| wr_dma_i | input | 1 | Write comes from the DMA master |
| wr_ack_o | output | 1 | Write completion pulse |
| rd_req_i | input | 1 | Read request, held until `rd_ack_o` |
| rd_addr_i | input | AW | Read address (half-word units) |
| rd_wide_i | input | 1 | Read is 32-bit |
| rd_dma_i | input | 1 | Read comes from the DMA master |
| rd_ack_o | output | 1 | Read completion pulse |
| rd_data_o | output | DW | Read data, valid with `rd_ack_o` |
| err_o | output | 1 | Error flag, valid with an acknowledge |
| p_sel_o | output | NF | One-hot frame select |
| p_addr_o | output | PAW | Peripheral address (offset within frame) |
| p_wr_o | output | 1 | Peripheral write strobe |
| p_rd_o | output | 1 | Peripheral read strobe |
| p_wide_o | output | 1 | Peripheral transfer is 32-bit |
| p_wdata_o | output | DW | Peripheral write data |
| p_rdata_i | input | DW | Peripheral read data, sampled during a read strobe |

## Verification
The hardest cases to reach are those where frame bounds, master type, width and alignment all meet in one access. Examples are a misaligned 32-bit DMA access on the last half-word of the DMA frame, and a 32-bit access in the narrow frame whose second half-word lands on the frame's last offset. The bench runs the bridge with small, closely packed frames separated by gaps. It sweeps every address from below the first frame to past the last one, under all eight combinations of direction, width and master. This makes every edge of every window meet every policy. A separate test raises both request channels in the same cycle to check the service order.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned FR_WIDE = 0;
  localparam int unsigned FR_NARROW = 1;
  localparam int unsigned FR_DMA = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STB_LO,
    ST_STB_HI,
    ST_ACK,
    ST_ERR
  } seq_state_e;
endpackage

// File: rtl/pbus_arb.sv
module pbus_arb #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          wr_req_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_wide_i,
  input  logic          wr_dma_i,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          rd_wide_i,
  input  logic          rd_dma_i,
  output logic          go_o,
  output logic          write_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          wide_o,
  output logic          dma_o
);
  // writes outrank reads
  always_comb begin
    go_o    = wr_req_i | rd_req_i;
    write_o = wr_req_i;
    data_o  = wr_data_i;
    if (wr_req_i) begin
      addr_o = wr_addr_i;
      wide_o = wr_wide_i;
      dma_o  = wr_dma_i;
    end else begin
      addr_o = rd_addr_i;
      wide_o = rd_wide_i;
      dma_o  = rd_dma_i;
    end
  end
endmodule

// File: rtl/pbus_frame_dec.sv
module pbus_frame_dec #(
  parameter int unsigned AW  = 32,
  parameter int unsigned PAW = 16,
  parameter int unsigned NF  = 3,
  parameter logic [NF-1:0][AW-1:0] BASE = '0,
  parameter logic [NF-1:0][AW-1:0] SIZE = '0
) (
  input  logic [AW-1:0]  addr_i,
  output logic [NF-1:0]  hit_o,
  output logic [PAW-1:0] off_o
);
  for (genvar k = 0; k < NF; k++) begin : g_win
    logic [AW:0] lo_b, hi_b, a_x;
    assign a_x  = {1'b0, addr_i};
    assign lo_b = {1'b0, BASE[k]};
    assign hi_b = {1'b0, BASE[k]} + {1'b0, SIZE[k]};
    assign hit_o[k] = (a_x >= lo_b) && (a_x < hi_b);
  end

  always_comb begin
    logic [AW-1:0] diff;
    diff  = '0;
    for (int k = NF - 1; k >= 0; k--) begin
      if (hit_o[k]) diff = addr_i - BASE[k];
    end
    off_o = diff[PAW-1:0];
  end
endmodule

// File: rtl/pbus_policy.sv
module pbus_policy #(
  parameter int unsigned NF = 3,
  parameter logic [NF-1:0] WIDE_OK = '1,
  parameter logic [NF-1:0] DMA_OK  = '0
) (
  input  logic [NF-1:0] hit_i,
  input  logic          wide_i,
  input  logic          dma_i,
  input  logic          addr_lsb_i,
  output logic          legal_o,
  output logic          split_o
);
  logic any_hit, dma_fit, native;

  always_comb begin
    any_hit = |hit_i;
    dma_fit = |(hit_i & DMA_OK);
    native  = |(hit_i & WIDE_OK);
    legal_o = any_hit && (!dma_i || dma_fit) && !(wide_i && addr_lsb_i);
    split_o = wide_i && !native;
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned PAW = 16,
  parameter int unsigned NF  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic           write_i,
  input  logic           wide_i,
  input  logic [DW-1:0]  data_i,
  input  logic [NF-1:0]  hit_i,
  input  logic [PAW-1:0] off_i,
  input  logic           legal_i,
  input  logic           split_i,
  input  logic [DW-1:0]  p_rdata_i,
  output logic           wr_ack_o,
  output logic           rd_ack_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           err_o,
  output logic [NF-1:0]  p_sel_o,
  output logic [PAW-1:0] p_addr_o,
  output logic           p_wr_o,
  output logic           p_rd_o,
  output logic           p_wide_o,
  output logic [DW-1:0]  p_wdata_o
);
  localparam int unsigned HW = DW / 2;

  seq_state_e    state_q;
  logic          write_q, wide_q, split_q;
  logic [DW-1:0] data_q, rbuf_q;
  logic [NF-1:0] sel_q;
  logic [PAW-1:0] off_q;
  logic          strobe, hi_phase, native;

  assign native   = wide_q && !split_q;
  assign hi_phase = (state_q == ST_STB_HI);
  assign strobe   = (state_q == ST_STB_LO) || hi_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      split_q <= 1'b0;
      data_q  <= '0;
      rbuf_q  <= '0;
      sel_q   <= '0;
      off_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            write_q <= write_i;
            wide_q  <= wide_i;
            split_q <= split_i;
            data_q  <= data_i;
            sel_q   <= hit_i;
            off_q   <= off_i;
            if (legal_i) begin
              state_q <= ST_STB_LO;
            end else begin
              rbuf_q  <= '0;
              state_q <= ST_ERR;
            end
          end
        end
        ST_STB_LO: begin
          if (!write_q)
            rbuf_q <= native ? p_rdata_i : {{HW{1'b0}}, p_rdata_i[HW-1:0]};
          state_q <= split_q ? ST_STB_HI : ST_ACK;
        end
        ST_STB_HI: begin
          if (!write_q) rbuf_q[DW-1:HW] <= p_rdata_i[HW-1:0];
          state_q <= ST_ACK;
        end
        ST_ACK:  state_q <= ST_IDLE;
        ST_ERR:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    p_wr_o    = strobe && write_q;
    p_rd_o    = strobe && !write_q;
    p_sel_o   = strobe ? sel_q : '0;
    p_wide_o  = strobe && native;
    p_addr_o  = off_q + PAW'(hi_phase);
    p_wdata_o = '0;
    if (strobe && write_q) begin
      if (hi_phase)    p_wdata_o = {{HW{1'b0}}, data_q[DW-1:HW]};
      else if (native) p_wdata_o = data_q;
      else             p_wdata_o = {{HW{1'b0}}, data_q[HW-1:0]};
    end
    wr_ack_o  = ((state_q == ST_ACK) || (state_q == ST_ERR)) && write_q;
    rd_ack_o  = ((state_q == ST_ACK) || (state_q == ST_ERR)) && !write_q;
    err_o     = (state_q == ST_ERR);
    rd_data_o = rbuf_q;
  end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned PAW = 16,
  parameter int unsigned NF  = 3,
  parameter logic [NF-1:0][AW-1:0] FRM_BASE = {32'h0000_5000, 32'h0000_7000, 32'h0000_6000},
  parameter logic [NF-1:0][AW-1:0] FRM_SIZE = {32'h0000_1000, 32'h0000_1000, 32'h0000_1000},
  parameter logic [NF-1:0] FRM_WIDE_OK = NF'((1 << FR_WIDE) | (1 << FR_DMA)),
  parameter logic [NF-1:0] FRM_DMA_OK  = NF'(1 << FR_DMA)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_req_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           wr_wide_i,
  input  logic           wr_dma_i,
  output logic           wr_ack_o,
  input  logic           rd_req_i,
  input  logic [AW-1:0]  rd_addr_i,
  input  logic           rd_wide_i,
  input  logic           rd_dma_i,
  output logic           rd_ack_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           err_o,
  output logic [NF-1:0]  p_sel_o,
  output logic [PAW-1:0] p_addr_o,
  output logic           p_wr_o,
  output logic           p_rd_o,
  output logic           p_wide_o,
  output logic [DW-1:0]  p_wdata_o,
  input  logic [DW-1:0]  p_rdata_i
);
  logic           go, write, wide, dma, legal, split;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  data;
  logic [NF-1:0]  hit;
  logic [PAW-1:0] off;

  pbus_arb #(.AW(AW), .DW(DW)) u_arb (
    .wr_req_i (wr_req_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_wide_i(wr_wide_i), .wr_dma_i(wr_dma_i),
    .rd_req_i (rd_req_i), .rd_addr_i(rd_addr_i),
    .rd_wide_i(rd_wide_i), .rd_dma_i(rd_dma_i),
    .go_o(go), .write_o(write), .addr_o(addr), .data_o(data),
    .wide_o(wide), .dma_o(dma)
  );

  pbus_frame_dec #(
    .AW(AW), .PAW(PAW), .NF(NF), .BASE(FRM_BASE), .SIZE(FRM_SIZE)
  ) u_dec (
    .addr_i(addr), .hit_o(hit), .off_o(off)
  );

  pbus_policy #(
    .NF(NF), .WIDE_OK(FRM_WIDE_OK), .DMA_OK(FRM_DMA_OK)
  ) u_pol (
    .hit_i(hit), .wide_i(wide), .dma_i(dma), .addr_lsb_i(addr[0]),
    .legal_o(legal), .split_o(split)
  );

  pbus_seq #(.DW(DW), .PAW(PAW), .NF(NF)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .go_i(go), .write_i(write), .wide_i(wide), .data_i(data),
    .hit_i(hit), .off_i(off), .legal_i(legal), .split_i(split),
    .p_rdata_i(p_rdata_i),
    .wr_ack_o(wr_ack_o), .rd_ack_o(rd_ack_o), .rd_data_o(rd_data_o),
    .err_o(err_o), .p_sel_o(p_sel_o), .p_addr_o(p_addr_o),
    .p_wr_o(p_wr_o), .p_rd_o(p_rd_o), .p_wide_o(p_wide_o),
    .p_wdata_o(p_wdata_o)
  );
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
  parameter int unsigned DW  = 32,
  parameter int unsigned PAW = 16,
  parameter int unsigned NF  = 3,
  parameter logic [NF-1:0] WIDE_OK = '1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_ack_o,
  input logic           rd_ack_o,
  input logic [DW-1:0]  rd_data_o,
  input logic           err_o,
  input logic [NF-1:0]  p_sel_o,
  input logic [PAW-1:0] p_addr_o,
  input logic           p_wr_o,
  input logic           p_rd_o,
  input logic           p_wide_o
);
  logic stb;
  assign stb = p_wr_o || p_rd_o;

  p_rdwr_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(p_wr_o && p_rd_o));

  p_sel_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(p_sel_o) && ((p_sel_o != '0) == stb));

  p_ack_after_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o || wr_ack_o) && !err_o |-> $past(stb));

  p_err_no_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(stb) && !stb);

  p_err_with_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rd_ack_o || wr_ack_o));

  p_acks_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_ack_o && wr_ack_o));

  p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && rd_ack_o |-> rd_data_o == '0);

  p_split_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && $past(stb) |-> (p_addr_o == $past(p_addr_o) + PAW'(1)) && !p_wide_o
                          && $stable(p_sel_o) && $stable(p_wr_o));

  p_wide_native_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_wide_o |-> (p_sel_o & ~WIDE_OK) == '0);

  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r10: assert (!stb && !rd_ack_o && !wr_ack_o && !err_o);
    end
  end
endmodule

bind pbus_bridge pbus_bridge_chk #(
  .DW(DW), .PAW(PAW), .NF(NF), .WIDE_OK(FRM_WIDE_OK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_ack_o(wr_ack_o), .rd_ack_o(rd_ack_o),
  .rd_data_o(rd_data_o), .err_o(err_o), .p_sel_o(p_sel_o),
  .p_addr_o(p_addr_o), .p_wr_o(p_wr_o), .p_rd_o(p_rd_o), .p_wide_o(p_wide_o)
);

// File: tb/sim_pbus_bridge.sv
`timescale 1ns/1ps
module sim_pbus_bridge;
  localparam logic [31:0] B0 = 32'h40, S0 = 32'h20; // native wide
  localparam logic [31:0] B1 = 32'h80, S1 = 32'h20; // narrow
  localparam logic [31:0] B2 = 32'hC0, S2 = 32'h10; // DMA

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr_req = 0, wr_wide = 0, wr_dma = 0;
  logic [31:0] wr_addr = 0, wr_data = 0;
  logic        rd_req = 0, rd_wide = 0, rd_dma = 0;
  logic [31:0] rd_addr = 0;
  logic        wr_ack, rd_ack, err;
  logic [31:0] rd_data, p_wdata, p_rdata;
  logic [2:0]  p_sel;
  logic [15:0] p_addr;
  logic        p_wr, p_rd, p_wide;

  int checks = 0, fails = 0;

  function automatic logic [15:0] lo_f(int k, logic [15:0] a);
    return a ^ 16'(16'h1111 * (k + 1));
  endfunction
  function automatic logic [15:0] hi_f(int k, logic [15:0] a);
    return ~a + 16'(k);
  endfunction
  function automatic int sel_idx(logic [2:0] s);
    return s[1] ? 1 : (s[2] ? 2 : 0);
  endfunction

  assign p_rdata = {hi_f(sel_idx(p_sel), p_addr), lo_f(sel_idx(p_sel), p_addr)};

  pbus_bridge #(
    .FRM_BASE({B2, B1, B0}), .FRM_SIZE({S2, S1, S0})
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_wide_i(wr_wide), .wr_dma_i(wr_dma), .wr_ack_o(wr_ack),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_wide_i(rd_wide),
    .rd_dma_i(rd_dma), .rd_ack_o(rd_ack), .rd_data_o(rd_data),
    .err_o(err), .p_sel_o(p_sel), .p_addr_o(p_addr), .p_wr_o(p_wr),
    .p_rd_o(p_rd), .p_wide_o(p_wide), .p_wdata_o(p_wdata), .p_rdata_i(p_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  // one transaction, observed at negedges
  task automatic txn(input bit w, wide, dma, input logic [31:0] a, d);
    int k, nst, cyc, ack_cyc, last_stb;
    bit exp_err, got_err, split, done;
    logic [15:0] off, s_addr[4];
    logic [31:0] s_wd[4], exp_rd, got_rd;
    logic [2:0] s_sel[4];
    logic s_wide[4], s_dir[4];
    string t;
    k = -1;
    if (a >= B0 && a < B0 + S0) k = 0;
    else if (a >= B1 && a < B1 + S1) k = 1;
    else if (a >= B2 && a < B2 + S2) k = 2;
    exp_err = (k < 0) || (dma && k != 2) || (wide && a[0]);
    split = wide && (k == 1);
    case (k)
      0: off = 16'(a - B0);
      1: off = 16'(a - B1);
      2: off = 16'(a - B2);
      default: off = 16'h0;
    endcase
    @(negedge clk);
    if (w) begin
      wr_req = 1; wr_addr = a; wr_data = d; wr_wide = wide; wr_dma = dma;
    end else begin
      rd_req = 1; rd_addr = a; rd_wide = wide; rd_dma = dma;
    end
    nst = 0; cyc = 0; ack_cyc = 0; last_stb = 0; done = 0;
    got_err = 0; got_rd = 0;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if ((p_wr || p_rd) && nst < 4) begin
        s_addr[nst] = p_addr; s_wd[nst] = p_wdata; s_sel[nst] = p_sel;
        s_wide[nst] = p_wide; s_dir[nst] = p_wr;
        nst++; last_stb = cyc;
      end
      if (w ? wr_ack : rd_ack) begin
        done = 1; ack_cyc = cyc; got_err = err; got_rd = rd_data;
      end
    end
    wr_req = 0; rd_req = 0;
    if (!done) begin
      chk(0, "R2 ack timeout", 0, 1);
      return;
    end
    if (k < 0) t = "R7";
    else if (dma && k != 2) t = "R6";
    else if (wide && a[0]) t = "R8";
    else if (dma) t = "R6";
    else t = "R2";
    chk(got_err == exp_err, {t, " err flag"}, 32'(got_err), 32'(exp_err));
    if (exp_err) begin
      chk(nst == 0, {t, " no strobe"}, nst, 0);
      chk(ack_cyc == 1, {t, " err ack timing"}, ack_cyc, 1);
      if (!w) chk(got_rd == 0, {t, " err read zero"}, got_rd, 0);
      return;
    end
    chk(nst == (split ? 2 : 1), split ? "R4 strobe count" : "R2 strobe count",
        nst, split ? 2 : 1);
    chk(ack_cyc == last_stb + 1 && last_stb == nst, "R2 ack timing", ack_cyc, nst + 1);
    t = split ? "R4" : (wide ? "R3" : "R5");
    for (int i = 0; i < nst && i < 2; i++) begin
      chk(s_sel[i] == 3'(1 << k), "R1 frame select", 32'(s_sel[i]), 32'(1 << k));
      chk(s_addr[i] == off + 16'(i), "R1 offset address", 32'(s_addr[i]), 32'(off + 16'(i)));
      chk(s_dir[i] == w, "R2 direction", 32'(s_dir[i]), 32'(w));
      chk(s_wide[i] == (wide && !split), {t, " wide flag"}, 32'(s_wide[i]),
          32'(wide && !split));
      if (w) begin
        logic [31:0] ew;
        if (split) ew = (i == 0) ? {16'h0, d[15:0]} : {16'h0, d[31:16]};
        else if (wide) ew = d;
        else ew = {16'h0, d[15:0]};
        chk(s_wd[i] == ew, {t, " write data"}, s_wd[i], ew);
      end
    end
    if (!w) begin
      if (split) exp_rd = {lo_f(1, off + 16'd1), lo_f(1, off)};
      else if (wide) exp_rd = {hi_f(k, off), lo_f(k, off)};
      else exp_rd = {16'h0, lo_f(k, off)};
      chk(got_rd == exp_rd, {t, " read data"}, got_rd, exp_rd);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: quiet while in reset
    chk(!p_wr && !p_rd && p_sel == 0, "R10 strobes in reset", {p_wr, p_rd, p_sel}, 0);
    chk(!wr_ack && !rd_ack && !err, "R10 acks in reset", {wr_ack, rd_ack, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!p_wr && !p_rd && !wr_ack && !rd_ack, "R10 idle after reset",
        {p_wr, p_rd, wr_ack, rd_ack}, 0);

    for (int a = 32'h30; a < 32'hE0; a++) begin
      for (int m = 0; m < 8; m++) begin
        txn(m[0], m[1], m[2], 32'(a), {16'(a) ^ 16'hC3C3, ~16'(a) + 16'(m)});
      end
    end

    // R9: both channels raised together
    begin
      int cyc, first_wr, wr_seen, rd_seen;
      @(negedge clk);
      wr_req = 1; wr_addr = B0 + 2; wr_data = 32'hDEAD_BEEF; wr_wide = 1; wr_dma = 0;
      rd_req = 1; rd_addr = B1 + 4; rd_wide = 0; rd_dma = 0;
      cyc = 0; first_wr = -1; wr_seen = 0; rd_seen = 0;
      while (!rd_seen && cyc < 20) begin
        @(negedge clk);
        cyc++;
        if (first_wr < 0 && (p_wr || p_rd)) first_wr = p_wr ? 1 : 0;
        if (wr_ack) begin wr_seen = cyc; wr_req = 0; end
        if (rd_ack) begin rd_seen = cyc; rd_req = 0; end
      end
      wr_req = 0; rd_req = 0;
      chk(first_wr == 1, "R9 write strobed first", first_wr, 1);
      chk(wr_seen == 2, "R9 write ack cycle", wr_seen, 2);
      chk(rd_seen == 5, "R9 read ack cycle", rd_seen, 5);
      chk(rd_data == {16'h0, lo_f(1, 16'd4)}, "R9 read data", rd_data,
          {16'h0, lo_f(1, 16'd4)});
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule